// File: doc/BRIEF.md
# DDR2 Mode Register Timing Guard

This block sits beside the command path of a DDR2 memory controller and follows what each mode-register-set write does to later traffic. It keeps the register image, decodes the write-recovery, DLL-reset, power-down-exit and test-mode fields, and turns them into gating. While the DLL relocks after a reset, it holds READ commands off. After the final data beat of a write with auto-precharge, it times the internal precharge for each bank.

The scheduler presents every mode-register write on `mrs_wr`/`mrs_word`. It reports the final beat of each auto-precharge write on `wap_last`/`wap_bank`. It asks whether a bank is free by driving `cmd_bank` and reading `cmd_blocked`. The READ path waits for `rd_permit`. Illegal programming shows up as one-cycle error pulses.

Top module: `mrg_guard`

## Requirements
- R1: After reset, `rd_permit` is 1, no bank is busy, no precharge pulse is raised, `slow_exit` is 0, `wr_clks` is 2, `mr_image` has only the write-recovery code 001 (bits 11:9) set, and both error flags are 0.
- R2: A write with bit 7 set is a test-mode request. `err_test` is 1 for exactly the cycle after the write. The image, `wr_clks`, `slow_exit` and the lockout are left untouched.
- R3: An accepted write stores its word in `mr_image` on the write edge. Bit 8 (DLL reset) always reads back 0.
- R4: An accepted write with bit 8 set drives `rd_permit` low for exactly LOCK_CYC (200) cycles, starting the cycle after the write edge.
- R5: A new DLL-reset write during a lockout restarts the full LOCK_CYC window from that write.
- R6: An accepted write with write-recovery code c in bits 11:9, c from 001 to 111, sets `wr_clks` to c+1 (2 to 8).
- R7: An accepted write with code 000 pulses `err_rsvd` for one cycle and keeps the previous write-recovery value and image bits 11:9. All other fields of the write still apply.
- R8: If `wap_last` is sampled for bank b at edge k, `pre_fire[b]` is high for exactly one cycle, the one that ends at edge k+WR. WR is the `wr_clks` value held before edge k.
- R9: Bank b is busy (`bank_busy[b]`, and `cmd_blocked` when `cmd_bank` = b) from the cycle after the last beat until its precharge edge. A last beat for a bank that is already busy is ignored. Banks time independently.
- R10: `slow_exit` follows bit 12 of the last accepted write (0 fast exit, 1 slow exit).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mrs_wr | input | 1 | Mode-register write strobe |
| mrs_word | input | MR_W | Mode-register data word |
| wap_last | input | 1 | Final data beat of a write with auto-precharge |
| wap_bank | input | log2(NBANK) | Bank of that write |
| cmd_bank | input | log2(NBANK) | Bank being considered for a new command |
| rd_permit | output | 1 | READ commands allowed |
| cmd_blocked | output | 1 | `cmd_bank` has a pending precharge |
| bank_busy | output | NBANK | Pending precharge, per bank |
| pre_fire | output | NBANK | One-cycle internal precharge pulse, per bank |
| wr_clks | output | 4 | Current write recovery in clocks |
| slow_exit | output | 1 | Active power-down exit type |
| mr_image | output | MR_W | Stored mode-register word |
| err_test | output | 1 | Test-mode write rejected |
| err_rsvd | output | 1 | Reserved write-recovery code seen |

## Verification
The properties assume that `mrs_word` holds known values whenever `mrs_wr` is high. They also assume that reset is applied before the first strobe. No assumption is made about how often writes or last beats arrive: a last beat to a busy bank is legal input.

The stimulus drives every input one nanosecond after a rising edge and never leaves X on the data word. It mixes random write rates, test and reserved codes, and repeated DLL resets with directed runs that count the lockout and the precharge delay exactly.

// File: rtl/mrg_pkg.sv
// Shared field positions, types and decode helpers for the mode register guard.
// Assumes the mode word is at least 13 bits wide.
package mrg_pkg;
    localparam int TM_BIT  = 7;
    localparam int DLL_BIT = 8;
    localparam int WR_LO   = 9;
    localparam int WR_HI   = 11;
    localparam int PD_BIT  = 12;
    localparam int WRC_W   = 4;

    typedef struct packed {
        logic       test;
        logic       dll;
        logic [2:0] wr_code;
        logic       slow;
    } mr_fields_t;

    // Pull the fields this block acts on out of the low 13 bits of a word.
    function automatic mr_fields_t get_fields(input logic [PD_BIT:0] w);
        mr_fields_t f;
        f.test    = w[TM_BIT];
        f.dll     = w[DLL_BIT];
        f.wr_code = w[WR_HI:WR_LO];
        f.slow    = w[PD_BIT];
        return f;
    endfunction

    // Code 001..111 gives 2..8 clocks; code 000 is reserved.
    function automatic logic [WRC_W-1:0] wr_from_code(input logic [2:0] c);
        return {1'b0, c} + WRC_W'(1);
    endfunction
endpackage

// File: rtl/mrg_mode_reg.sv
// Mode register image and field decode.
// What it does: accepts writes unless the test-mode bit is set, stores the
// word with the DLL-reset bit cleared, keeps the previous write recovery when
// the code is reserved, and raises one-cycle error flags.
// Assumes: mrs_word is known whenever mrs_wr is high.
module mrg_mode_reg
    import mrg_pkg::*;
#(
    parameter int MR_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mrs_wr,
    input  logic [MR_W-1:0]  mrs_word,
    output logic [MR_W-1:0]  mr_image,
    output logic [WRC_W-1:0] wr_clks,
    output logic             slow_exit,
    output logic             err_test,
    output logic             err_rsvd,
    output logic             dll_load
);
    localparam logic [MR_W-1:0] IMG_RST = MR_W'(1) << WR_LO;

    mr_fields_t      fld;
    logic            accept;
    logic            rsvd;
    logic [MR_W-1:0] img_nxt;

    // Decode the incoming word and form the next image.
    always_comb begin
        fld      = get_fields(mrs_word[PD_BIT:0]);
        accept   = mrs_wr && !fld.test;
        rsvd     = (fld.wr_code == 3'b000);
        dll_load = accept && fld.dll;
        img_nxt  = mrs_word;
        img_nxt[DLL_BIT] = 1'b0;
        if (rsvd) begin
            img_nxt[WR_HI:WR_LO] = mr_image[WR_HI:WR_LO];
        end
    end

    // Hold the image and decoded settings.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mr_image  <= IMG_RST;
            wr_clks   <= WRC_W'(2);
            slow_exit <= 1'b0;
        end else if (accept) begin
            mr_image  <= img_nxt;
            slow_exit <= fld.slow;
            if (!rsvd) begin
                wr_clks <= wr_from_code(fld.wr_code);
            end
        end
    end

    // One-cycle error pulses for rejected or partly applied writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_test <= 1'b0;
            err_rsvd <= 1'b0;
        end else begin
            err_test <= mrs_wr && fld.test;
            err_rsvd <= accept && rsvd;
        end
    end
endmodule

// File: rtl/mrg_read_lock.sv
// DLL relock READ lockout.
// What it does: loads LOCK_CYC on a DLL reset and counts down to zero; READ
// is permitted only at zero. A reload during the count restarts it.
// Assumes: LOCK_CYC >= 1.
module mrg_read_lock #(
    parameter int LOCK_CYC = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic rd_permit
);
    localparam int CNT_W = $clog2(LOCK_CYC + 1);

    logic [CNT_W-1:0] cnt;

    // Count the remaining relock cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= CNT_W'(LOCK_CYC);
        end else if (cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    // READ allowed once the count is exhausted.
    always_comb rd_permit = (cnt == '0);
endmodule

// File: rtl/mrg_ap_timer.sv
// Per-bank auto-precharge delay timer.
// What it does: on a last data beat for an idle bank, loads the write
// recovery value; the precharge pulse is raised in the cycle whose closing
// edge lies WR edges after the load edge. A load while busy is ignored.
// Assumes: wr_clks is at least 2.
module mrg_ap_timer
    import mrg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             last_beat,
    input  logic [WRC_W-1:0] wr_clks,
    output logic             busy,
    output logic             fire
);
    logic [WRC_W-1:0] cnt;

    // Load on an idle last beat, otherwise count down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (last_beat && cnt == '0) begin
            cnt <= wr_clks;
        end else if (cnt != '0) begin
            cnt <= cnt - WRC_W'(1);
        end
    end

    // Busy while a precharge is owed; fire in its final cycle.
    always_comb begin
        busy = (cnt != '0);
        fire = (cnt == WRC_W'(1));
    end
endmodule

// File: rtl/mrg_guard.sv
// Mode register timing guard, top level.
// What it does: ties the register image, READ lockout and one precharge
// timer per bank together, and answers whether a bank is free.
// Assumes: NBANK is a power of two; MR_W >= 13.
module mrg_guard
    import mrg_pkg::*;
#(
    parameter int NBANK    = 8,
    parameter int LOCK_CYC = 200,
    parameter int MR_W     = 13,
    localparam int BANK_W  = $clog2(NBANK)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mrs_wr,
    input  logic [MR_W-1:0]   mrs_word,
    input  logic              wap_last,
    input  logic [BANK_W-1:0] wap_bank,
    input  logic [BANK_W-1:0] cmd_bank,
    output logic              rd_permit,
    output logic              cmd_blocked,
    output logic [NBANK-1:0]  bank_busy,
    output logic [NBANK-1:0]  pre_fire,
    output logic [WRC_W-1:0]  wr_clks,
    output logic              slow_exit,
    output logic [MR_W-1:0]   mr_image,
    output logic              err_test,
    output logic              err_rsvd
);
    logic dll_load;

    mrg_mode_reg #(.MR_W(MR_W)) u_mreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .mrs_wr    (mrs_wr),
        .mrs_word  (mrs_word),
        .mr_image  (mr_image),
        .wr_clks   (wr_clks),
        .slow_exit (slow_exit),
        .err_test  (err_test),
        .err_rsvd  (err_rsvd),
        .dll_load  (dll_load)
    );

    mrg_read_lock #(.LOCK_CYC(LOCK_CYC)) u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (dll_load),
        .rd_permit (rd_permit)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic hit;
        // Route the last beat to its bank.
        always_comb hit = wap_last && (wap_bank == BANK_W'(b));
        mrg_ap_timer u_tmr (
            .clk       (clk),
            .rst_n     (rst_n),
            .last_beat (hit),
            .wr_clks   (wr_clks),
            .busy      (bank_busy[b]),
            .fire      (pre_fire[b])
        );
    end

    // Answer the scheduler's bank query.
    always_comb cmd_blocked = bank_busy[cmd_bank];
endmodule

// File: rtl/mrg_guard_chk.sv
// Property checker for mrg_guard, attached by bind.
module mrg_guard_chk
    import mrg_pkg::*;
#(
    parameter int NBANK = 8,
    parameter int MR_W  = 13
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mrs_wr,
    input logic [MR_W-1:0]  mrs_word,
    input logic             rd_permit,
    input logic [NBANK-1:0] bank_busy,
    input logic [NBANK-1:0] pre_fire,
    input logic [WRC_W-1:0] wr_clks,
    input logic             slow_exit,
    input logic [MR_W-1:0]  mr_image,
    input logic             err_test,
    input logic             err_rsvd
);
    p_test_reject_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mrs_wr && mrs_word[TM_BIT]) |=> (err_test && $stable(mr_image) && $stable(wr_clks)));

    p_dll_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mr_image[DLL_BIT] == 1'b0);

    p_lock_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mrs_wr && !mrs_word[TM_BIT] && mrs_word[DLL_BIT]) |=> !rd_permit);

    p_wr_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clks >= WRC_W'(2)) && (wr_clks <= WRC_W'(8)));

    p_rsvd_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mrs_wr && !mrs_word[TM_BIT] && mrs_word[WR_HI:WR_LO] == 3'b000)
        |=> (err_rsvd && $stable(wr_clks)));

    p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_fire != '0) |=> ((pre_fire & $past(pre_fire)) == '0));

    p_fire_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_fire & ~bank_busy) == '0);

    p_exit_type_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mrs_wr && !mrs_word[TM_BIT]) |=> (slow_exit == $past(mrs_word[PD_BIT])));
endmodule

bind mrg_guard mrg_guard_chk #(.NBANK(NBANK), .MR_W(MR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mrs_wr    (mrs_wr),
    .mrs_word  (mrs_word),
    .rd_permit (rd_permit),
    .bank_busy (bank_busy),
    .pre_fire  (pre_fire),
    .wr_clks   (wr_clks),
    .slow_exit (slow_exit),
    .mr_image  (mr_image),
    .err_test  (err_test),
    .err_rsvd  (err_rsvd)
);

// File: tb/tb_mrg_guard.sv
`timescale 1ns/1ps
module tb_mrg_guard;
    localparam int NB   = 8;
    localparam int BW   = 3;
    localparam int LOCK = 200;
    localparam int MW   = 13;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mrs_wr = 1'b0;
    logic [MW-1:0] mrs_word = '0;
    logic          wap_last = 1'b0;
    logic [BW-1:0] wap_bank = '0;
    logic [BW-1:0] cmd_bank = '0;
    logic          rd_permit, cmd_blocked, slow_exit, err_test, err_rsvd;
    logic [NB-1:0] bank_busy, pre_fire;
    logic [3:0]    wr_clks;
    logic [MW-1:0] mr_image;

    int n_run = 0;
    int n_fail = 0;
    bit model_on = 1'b0;

    always #2.5 clk = ~clk;

    mrg_guard #(.NBANK(NB), .LOCK_CYC(LOCK), .MR_W(MW)) dut (
        .clk(clk), .rst_n(rst_n), .mrs_wr(mrs_wr), .mrs_word(mrs_word),
        .wap_last(wap_last), .wap_bank(wap_bank), .cmd_bank(cmd_bank),
        .rd_permit(rd_permit), .cmd_blocked(cmd_blocked), .bank_busy(bank_busy),
        .pre_fire(pre_fire), .wr_clks(wr_clks), .slow_exit(slow_exit),
        .mr_image(mr_image), .err_test(err_test), .err_rsvd(err_rsvd)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Bench functions computing expectations from the requirements.
    function automatic int wr_of(input logic [2:0] code, input int prev);
        return (code == 3'b000) ? prev : int'(code) + 1;
    endfunction

    function automatic logic [MW-1:0] mk(input bit tm, input bit dll, input logic [2:0] code,
                                         input bit slow, input logic [6:0] low);
        logic [MW-1:0] w;
        w = '0;
        w[6:0] = low;
        w[7] = tm;
        w[8] = dll;
        w[11:9] = code;
        w[12] = slow;
        return w;
    endfunction

    // Reference state built from the requirements.
    logic [MW-1:0] m_img;
    int m_wr, m_lock;
    bit m_slow, m_et, m_er;
    int m_cnt [NB];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_img <= MW'(13'h0200); m_wr <= 2; m_lock <= 0; m_slow <= 0;
            m_et <= 0; m_er <= 0;
            for (int b = 0; b < NB; b++) m_cnt[b] <= 0;
        end else begin
            logic [MW-1:0] nw;
            m_et <= mrs_wr && mrs_word[7];
            m_er <= mrs_wr && !mrs_word[7] && mrs_word[11:9] == 3'b000;
            if (mrs_wr && !mrs_word[7]) begin
                nw = mrs_word;
                nw[8] = 1'b0;
                if (mrs_word[11:9] == 3'b000) nw[11:9] = m_img[11:9];
                m_img  <= nw;
                m_slow <= mrs_word[12];
                m_wr   <= wr_of(mrs_word[11:9], m_wr);
            end
            if (mrs_wr && !mrs_word[7] && mrs_word[8]) m_lock <= LOCK;
            else if (m_lock > 0) m_lock <= m_lock - 1;
            for (int b = 0; b < NB; b++) begin
                if (wap_last && int'(wap_bank) == b && m_cnt[b] == 0) m_cnt[b] <= m_wr;
                else if (m_cnt[b] > 0) m_cnt[b] <= m_cnt[b] - 1;
            end
        end
    end

    // Compare every output with the reference between edges.
    always @(negedge clk) begin
        if (model_on && rst_n) begin
            chk(rd_permit == (m_lock == 0), "R4/R5 rd_permit", int'(rd_permit), int'(m_lock == 0));
            chk(int'(wr_clks) == m_wr, "R6 wr_clks", int'(wr_clks), m_wr);
            chk(slow_exit == m_slow, "R10 slow_exit", int'(slow_exit), int'(m_slow));
            chk(mr_image == m_img, "R3 mr_image", int'(mr_image), int'(m_img));
            chk(err_test == m_et, "R2 err_test", int'(err_test), int'(m_et));
            chk(err_rsvd == m_er, "R7 err_rsvd", int'(err_rsvd), int'(m_er));
            for (int b = 0; b < NB; b++) begin
                chk(bank_busy[b] == (m_cnt[b] != 0), "R9 bank_busy", int'(bank_busy[b]), int'(m_cnt[b] != 0));
                chk(pre_fire[b] == (m_cnt[b] == 1), "R8 pre_fire", int'(pre_fire[b]), int'(m_cnt[b] == 1));
            end
            chk(cmd_blocked == (m_cnt[cmd_bank] != 0), "R9 cmd_blocked", int'(cmd_blocked), int'(m_cnt[cmd_bank] != 0));
        end
    end

    task automatic mrs(input logic [MW-1:0] w);
        @(posedge clk); #1;
        mrs_wr = 1'b1; mrs_word = w;
        @(posedge clk); #1;
        mrs_wr = 1'b0;
    endtask

    task automatic beat(input int b);
        @(posedge clk); #1;
        wap_last = 1'b1; wap_bank = BW'(b);
        @(posedge clk); #1;
        wap_last = 1'b0;
    endtask

    task automatic count_lock(input string req);
        int n = 0;
        while (n < LOCK + 10) begin
            @(negedge clk);
            if (rd_permit) break;
            n++;
        end
        chk(n == LOCK, req, n, LOCK);
    endtask

    task automatic fire_timing(input int b, input int wr, input string req);
        int c = 0;
        cmd_bank = BW'(b);
        beat(b);
        while (c < 20) begin
            @(negedge clk);
            c++;
            if (pre_fire[b]) break;
            chk(cmd_blocked == 1'b1, "R9 blocked while pending", int'(cmd_blocked), 1);
        end
        chk(c == wr, req, c, wr);
        @(negedge clk);
        chk(pre_fire[b] == 1'b0, "R8 pulse is one cycle", int'(pre_fire[b]), 0);
        chk(bank_busy[b] == 1'b0, "R9 free after precharge", int'(bank_busy[b]), 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        int unsigned seed;
        seed = $urandom(32'd4711);
        repeat (4) @(posedge clk);
        #1;
        @(negedge clk);
        // R1 reset state
        chk(rd_permit == 1'b1, "R1 rd_permit", int'(rd_permit), 1);
        chk(bank_busy == '0, "R1 bank_busy", int'(bank_busy), 0);
        chk(pre_fire == '0, "R1 pre_fire", int'(pre_fire), 0);
        chk(wr_clks == 4'd2, "R1 wr_clks", int'(wr_clks), 2);
        chk(slow_exit == 1'b0, "R1 slow_exit", int'(slow_exit), 0);
        chk(mr_image == 13'h0200, "R1 mr_image", int'(mr_image), 'h200);
        chk(!err_test && !err_rsvd, "R1 error flags", int'({err_test, err_rsvd}), 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        model_on = 1'b1;

        // R6, R10, R3: plain write
        mrs(mk(0, 0, 3'd7, 1, 7'h15));
        @(negedge clk);
        chk(wr_clks == 4'd8, "R6 code 111 gives 8", int'(wr_clks), 8);
        chk(slow_exit == 1'b1, "R10 slow exit set", int'(slow_exit), 1);
        chk(mr_image == mk(0, 0, 3'd7, 1, 7'h15), "R3 image stored", int'(mr_image), int'(mk(0, 0, 3'd7, 1, 7'h15)));
        fire_timing(3, 8, "R8 delay with WR 8");

        // R2 test mode rejected
        mrs(mk(1, 1, 3'd2, 0, 7'h00));
        @(negedge clk);
        chk(err_test == 1'b1, "R2 err_test pulse", int'(err_test), 1);
        chk(slow_exit == 1'b1, "R2 slow_exit untouched", int'(slow_exit), 1);
        chk(wr_clks == 4'd8, "R2 wr_clks untouched", int'(wr_clks), 8);
        chk(rd_permit == 1'b1, "R2 no lockout", int'(rd_permit), 1);
        @(negedge clk);
        chk(err_test == 1'b0, "R2 pulse one cycle", int'(err_test), 0);

        // R7 reserved code keeps WR, applies the rest
        mrs(mk(0, 0, 3'd0, 0, 7'h2a));
        @(negedge clk);
        chk(err_rsvd == 1'b1, "R7 err_rsvd pulse", int'(err_rsvd), 1);
        chk(wr_clks == 4'd8, "R7 wr_clks kept", int'(wr_clks), 8);
        chk(slow_exit == 1'b0, "R7 other fields applied", int'(slow_exit), 0);

        // R3, R4 DLL reset: bit clears, exact lockout
        mrs(mk(0, 1, 3'd1, 0, 7'h01));
        chk(mr_image[8] == 1'b0, "R3 DLL bit reads 0", int'(mr_image[8]), 0);
        count_lock("R4 lockout length");
        fire_timing(0, 2, "R8 delay with WR 2");

        // R5 restart during a countdown
        mrs(mk(0, 1, 3'd4, 0, 7'h00));
        repeat (100) @(negedge clk);
        chk(rd_permit == 1'b0, "R5 still locked midway", int'(rd_permit), 0);
        mrs(mk(0, 1, 3'd4, 0, 7'h00));
        count_lock("R5 restarted lockout length");

        // R9 last beat to a busy bank is ignored
        cmd_bank = 3'd5;
        beat(5);
        beat(5);
        repeat (3) @(negedge clk);
        chk(pre_fire[5] == 1'b1, "R9 second beat ignored", int'(pre_fire[5]), 1);

        // Random phase checked against the reference
        repeat (4000) begin
            @(posedge clk); #1;
            mrs_wr   = ($urandom % 16) == 0;
            mrs_word = mk(($urandom % 8) == 0, ($urandom % 10) == 0, 3'($urandom),
                          1'($urandom), 7'($urandom));
            wap_last = ($urandom % 3) == 0;
            wap_bank = BW'($urandom);
            cmd_bank = BW'($urandom);
        end
        @(posedge clk); #1;
        mrs_wr = 1'b0; wap_last = 1'b0;
        repeat (5) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule